// File: doc/BRIEF.md
# Bus Transfer Beat Sequencer

This block turns one processor memory request into the ordered list of data beats that a multiplexed address/data system bus must carry. A request is either a single datum of one to eight bytes at any byte address, or a block fill of one whole cache line of eight 32-bit words. The bus can run 64 bits wide or 32 bits wide, picked by a static configuration input. The block emits one transfer descriptor per beat: the byte address of the beat, how many bytes it moves, and a flag on the final beat of the request.

On a wide bus a line fill needs four doubleword beats and a single datum always fits in one beat. On a narrow bus a line fill needs eight word beats. A single datum that runs past a 32-bit word boundary is cut into two beats, so that no beat ever reaches outside one bus lane. The handshake with the bus, the command encodings and the movement of data are handled by neighbouring logic. Only one request is in flight at a time. A new request is taken only after the last descriptor of the current one has been handed downstream.

Top module: `beat_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `beat_valid` is 0.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. The first descriptor is valid in the next cycle. `req_ready` stays 0 while any descriptor of that request is still pending.
- R3: With `wide`=1, a block request (`req_block`=1) gives four descriptors. Each carries 8 bytes, at the line base (the request address with its low 5 bits cleared) plus 0, 8, 16 and 24.
- R4: With `wide`=0, a block request gives eight descriptors. Each carries 4 bytes, at the line base plus 4*i for i = 0..7.
- R5: With `wide`=1, a single-datum request (`req_size` = byte count 1..8, legal only when the address low 3 bits plus the size are at most 8) gives one descriptor holding the request address and size unchanged.
- R6: With `wide`=0, a single datum whose address low 2 bits plus size is at most 4 gives one descriptor holding the request address and size unchanged.
- R7: With `wide`=0, a single datum whose address low 2 bits plus size exceeds 4 gives two descriptors. The first is at the request address with 4 minus the address low 2 bits bytes. The second is at the next 4-byte-aligned address with the remaining bytes.
- R8: `beat_last` is 1 on the final descriptor of every request and 0 on every other one.
- R9: While `beat_valid` is 1 and `beat_ready` is 0, the descriptor fields hold their values into the next cycle.
- R10: Every descriptor carries at least one byte and stays inside one bus lane: the address offset within the lane (8 bytes wide, 4 bytes narrow) plus the byte count is at most the lane width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide | input | 1 | Bus width select: 1 = 64-bit, 0 = 32-bit; changed only while idle |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 32 | Request byte address |
| req_size | input | 4 | Single-datum byte count, 1..8 |
| req_block | input | 1 | 1 = cache-line block request, size ignored |
| beat_valid | output | 1 | Descriptor valid |
| beat_ready | input | 1 | Downstream takes the descriptor |
| beat_addr | output | 32 | Byte address of the beat |
| beat_bytes | output | 4 | Byte count of the beat |
| beat_last | output | 1 | Final beat of the request |

## Verification
The bound checker watches every cycle for descriptor stability under back-pressure, lane containment and non-zero byte counts, the valid descriptor that follows each accepted request, and the link between the last flag and the end or continuation of a burst. What those properties cannot show is the exact address and byte count of each beat. That includes the split point of a narrow-bus datum and the line-base alignment of block fills. The bench's scoreboard scenarios cover these, across both widths, with random downstream stalls and requests queued behind a busy sequencer.

// File: rtl/beat_seq_pkg.sv
package beat_seq_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_BYTES = 4;
    localparam int LINE_WORDS = 8;
    localparam int DW_BYTES   = 2 * WORD_BYTES;
    localparam int LINE_BYTES = WORD_BYTES * LINE_WORDS;
    localparam int OFF_W      = $clog2(DW_BYTES);
    localparam int LINE_OFF_W = $clog2(LINE_BYTES);
    localparam int CNT_W      = $clog2(DW_BYTES + 1);
    localparam int LEFT_W     = $clog2(LINE_BYTES + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [LEFT_W-1:0] left_t;

    // one descriptor as it leaves the block
    typedef struct packed {
        addr_t addr;
        cnt_t  nbytes;
        logic  last;
    } beat_t;

    // walk state: where the next beat starts and how many bytes remain
    typedef struct packed {
        addr_t addr;
        left_t left;
    } walk_t;

    function automatic left_t lane_bytes(logic wide);
        return wide ? left_t'(DW_BYTES) : left_t'(WORD_BYTES);
    endfunction

    function automatic addr_t start_addr(addr_t a, logic blk);
        return blk ? {a[ADDR_W-1:LINE_OFF_W], {LINE_OFF_W{1'b0}}} : a;
    endfunction

endpackage

// File: rtl/beat_seq_calc.sv
module beat_seq_calc
    import beat_seq_pkg::*;
(
    input  walk_t cur,
    input  logic  wide,
    output beat_t beat,
    output walk_t nxt
);
    left_t lane;
    left_t off;
    left_t room;
    left_t take;

    always_comb begin
        lane = lane_bytes(wide);
        off  = left_t'(cur.addr[OFF_W-1:0]) & (lane - left_t'(1));
        room = lane - off;
        take = (cur.left < room) ? cur.left : room;

        beat.addr   = cur.addr;
        beat.nbytes = cnt_t'(take);
        beat.last   = (cur.left == take);

        nxt.addr = (cur.addr & ~addr_t'(lane - left_t'(1))) + addr_t'(lane);
        nxt.left = cur.left - take;
    end
endmodule

// File: rtl/beat_seq_ctrl.sv
module beat_seq_ctrl
    import beat_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    output logic  req_ready,
    input  addr_t req_addr,
    input  cnt_t  req_size,
    input  logic  req_block,
    output logic  beat_valid,
    input  logic  beat_ready,
    input  logic  beat_is_last,
    input  walk_t nxt,
    output walk_t cur
);
    logic busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cur  <= '0;
        end else if (!busy) begin
            if (req_valid) begin
                busy     <= 1'b1;
                cur.addr <= start_addr(req_addr, req_block);
                cur.left <= req_block ? left_t'(LINE_BYTES) : left_t'(req_size);
            end
        end else if (beat_ready) begin
            if (beat_is_last) busy <= 1'b0;
            else              cur  <= nxt;
        end
    end

    assign req_ready  = !busy;
    assign beat_valid = busy;
endmodule

// File: rtl/beat_seq.sv
module beat_seq
    import beat_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_size,
    input  logic              req_block,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [CNT_W-1:0]  beat_bytes,
    output logic              beat_last
);
    walk_t cur;
    walk_t nxt;
    beat_t beat;

    beat_seq_ctrl ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_size     (req_size),
        .req_block    (req_block),
        .beat_valid   (beat_valid),
        .beat_ready   (beat_ready),
        .beat_is_last (beat.last),
        .nxt          (nxt),
        .cur          (cur)
    );

    beat_seq_calc calc_i (
        .cur  (cur),
        .wide (wide),
        .beat (beat),
        .nxt  (nxt)
    );

    assign beat_addr  = beat.addr;
    assign beat_bytes = beat.nbytes;
    assign beat_last  = beat.last;
endmodule

// File: rtl/beat_seq_chk.sv
module beat_seq_chk
    import beat_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wide,
    input logic              req_valid,
    input logic              req_ready,
    input logic              beat_valid,
    input logic              beat_ready,
    input logic [ADDR_W-1:0] beat_addr,
    input logic [CNT_W-1:0]  beat_bytes,
    input logic              beat_last
);
    logic [CNT_W:0] lane_w;
    logic [CNT_W:0] lane_off;

    always_comb begin
        lane_w   = wide ? (CNT_W+1)'(DW_BYTES) : (CNT_W+1)'(WORD_BYTES);
        lane_off = (CNT_W+1)'(beat_addr[OFF_W-1:0]) & (lane_w - (CNT_W+1)'(1));
    end

    p_first_beat_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> beat_valid);

    p_last_ends_r8: assert property (@(posedge clk) disable iff (rst)
        beat_valid && beat_ready && beat_last |=> !beat_valid);

    p_more_follow_r8: assert property (@(posedge clk) disable iff (rst)
        beat_valid && beat_ready && !beat_last |=> beat_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr)
            && $stable(beat_bytes) && $stable(beat_last));

    p_in_lane_r10: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (beat_bytes != '0)
            && (lane_off + (CNT_W+1)'(beat_bytes) <= lane_w));
endmodule

bind beat_seq beat_seq_chk chk_i (.*);

// File: tb/beat_seq_tb_top.sv
module beat_seq_tb_top;
    import beat_seq_pkg::*;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  nbytes;
        logic              last;
        int                req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wide = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [CNT_W-1:0]  req_size = '0;
    logic              req_block = 1'b0;
    logic              beat_valid;
    logic              beat_ready = 1'b0;
    logic [ADDR_W-1:0] beat_addr;
    logic [CNT_W-1:0]  beat_bytes;
    logic              beat_last;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    logic [15:0] lfsr = 16'hACE1;
    logic free_run = 1'b1;
    logic was_stall = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic [CNT_W-1:0]  prev_bytes = '0;
    logic              prev_last = 1'b0;

    always #2.5 clk = ~clk;

    beat_seq dut_i (.*);

    task automatic push(input logic [ADDR_W-1:0] a, input int n, input logic l, input int r);
        exp_t e;
        e.addr = a; e.nbytes = CNT_W'(n); e.last = l; e.req = r;
        q.push_back(e);
    endtask

    // independent expectation model
    task automatic send(input logic [ADDR_W-1:0] a, input int sz, input logic blk);
        int lo;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = CNT_W'(sz); req_block = blk;
        while (!req_ready) @(negedge clk);
        if (blk) begin
            // R3 wide: 4 x 8 bytes; R4 narrow: 8 x 4 bytes
            for (int i = 0; i < (wide ? 4 : 8); i++)
                push({a[ADDR_W-1:5], 5'b0} + ADDR_W'(i * (wide ? 8 : 4)), wide ? 8 : 4,
                     i == (wide ? 3 : 7), wide ? 3 : 4);
        end else if (wide) begin
            push(a, sz, 1'b1, 5);                       // R5
        end else begin
            lo = int'(a[1:0]);
            if (lo + sz <= 4) push(a, sz, 1'b1, 6);     // R6
            else begin                                  // R7
                push(a, 4 - lo, 1'b0, 7);
                push({a[ADDR_W-1:2], 2'b00} + 32'd4, sz - (4 - lo), 1'b1, 7);
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (!beat_valid) begin
            errors++;
            $display("FAIL R2: beat_valid=%0b expected 1 after accept", beat_valid);
        end
    endtask

    task automatic drain();
        @(negedge clk);
        while (q.size() != 0 || beat_valid) @(negedge clk);
        checks++;
        if (!req_ready) begin
            errors++;
            $display("FAIL R2: req_ready=%0b expected 1 when idle", req_ready);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (was_stall) begin
                checks++;
                if (beat_addr !== prev_addr || beat_bytes !== prev_bytes || beat_last !== prev_last) begin
                    errors++;
                    $display("FAIL R9: held %h/%0d/%0b expected %h/%0d/%0b",
                             beat_addr, beat_bytes, beat_last, prev_addr, prev_bytes, prev_last);
                end
            end
            beat_ready = free_run | lfsr[0];
            if (beat_valid && req_ready) begin
                errors++;
                $display("FAIL R2: req_ready=1 expected 0 while busy");
            end
            if (beat_valid && beat_ready) begin
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R8: unexpected beat %h/%0d expected none", beat_addr, beat_bytes);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (beat_addr !== e.addr || beat_bytes !== e.nbytes || beat_last !== e.last) begin
                        errors++;
                        $display("FAIL R%0d: beat %h/%0d/%0b expected %h/%0d/%0b (last flag per R8)",
                                 e.req, beat_addr, beat_bytes, beat_last, e.addr, e.nbytes, e.last);
                    end
                end
            end
            was_stall  = beat_valid && !beat_ready;
            prev_addr  = beat_addr;
            prev_bytes = beat_bytes;
            prev_last  = beat_last;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (req_ready !== 1'b1 || beat_valid !== 1'b0) begin   // R1
            errors++;
            $display("FAIL R1: ready/valid=%0b/%0b expected 1/0", req_ready, beat_valid);
        end

        // wide bus, no back-pressure
        wide = 1'b1;
        send(32'h1000_0047, 0, 1'b1);
        send(32'h0000_0100, 8, 1'b0);
        send(32'h0000_0103, 5, 1'b0);
        send(32'h0000_0107, 1, 1'b0);
        send(32'h0000_0104, 4, 1'b0);
        drain();

        // narrow bus, no back-pressure
        wide = 1'b0;
        send(32'h2000_005C, 0, 1'b1);
        send(32'h0000_0200, 8, 1'b0);
        send(32'h0000_0203, 5, 1'b0);
        send(32'h0000_0201, 2, 1'b0);
        send(32'h0000_0203, 2, 1'b0);
        send(32'h0000_0204, 4, 1'b0);
        send(32'h0000_0206, 2, 1'b0);
        drain();

        // random stalls, both widths
        free_run = 1'b0;
        send(32'h3000_0010, 0, 1'b1);
        send(32'h0000_0302, 6, 1'b0);
        send(32'h0000_0300, 1, 1'b0);
        drain();
        wide = 1'b1;
        send(32'h4000_00E8, 0, 1'b1);
        send(32'h0000_0402, 6, 1'b0);
        send(32'h0000_0400, 8, 1'b0);
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule